// File: doc/BRIEF.md
# MDIO Management Frame Controller

This block is a Clause-22 MDIO master. Software loads one 32-bit management word. The word packs a start code, an operation code, a 5-bit PHY address, a 5-bit register address, a turnaround code and a 16-bit data value. If the management port is enabled and the word is well formed, the block sends a 32-bit preamble of ones and then the word itself, MSB first, on the MDC/MDIO pins. During the send, the idle flag reads 0.

On a read, the block stops driving MDIO from the first turnaround bit onward. It samples the PHY's sixteen reply bits on the rising edges of MDC and shifts them into the data field of the stored word, so a read-back of the word returns the PHY's value once idle is 1 again. A 2-bit select sets the MDC period to 8, 16, 32 or 64 system clocks.

Top module: `mdio_frame_ctrl`

## Requirements
- R1: After reset, idle is 1, mdc is 0, mdio_oe is 0, mdio_o is 0 and rd_data is 0.
- R2: A wr_en pulse while idle is 1 stores wr_data, and rd_data shows it from the next cycle on. Fields by bit: [31:30] start, [29:28] op, [27:23] PHY address, [22:18] register address, [17:16] turnaround, [15:0] data.
- R3: A frame is launched only when three conditions hold. The enable input port_en is 1. The stored word has start 01, turnaround 10, and op 01 (write) or 10 (read). Otherwise idle stays 1 and mdc never toggles.
- R4: A frame is 64 MDC periods long. The value on mdio_o at each rising MDC edge is 1 for the first 32 bits, then bits 31 down to 0 of the word.
- R5: MDC has a period of 8, 16, 32 or 64 clocks for div_sel 0, 1, 2 or 3, with equal high and low halves.
- R6: While a frame runs, mdio_o changes only in the cycle in which mdc falls.
- R7: On a write frame, mdio_oe is 1 for all 64 bits. On a read frame, mdio_oe is 1 for bits 0 to 45 and 0 from bit 46 (the first turnaround bit) to the end. It is never raised again inside a frame.
- R8: On a read, mdio_i is sampled at the rising MDC edges of bits 48 to 63, MSB first, into bits [15:0] of the word. Bits [31:16] are unchanged.
- R9: idle is 0 from the cycle after launch until the last falling MDC edge, then 1. While idle is 1, mdc and mdio_oe are 0.
- R10: A wr_en pulse while idle is 0 is ignored: the stored word and the running frame are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Load-word strobe |
| wr_data | input | 32 | Management word to load |
| rd_data | output | 32 | Stored management word (read data lands in [15:0]) |
| port_en | input | 1 | Management port enable |
| div_sel | input | 2 | MDC ratio select: 8, 16, 32, 64 |
| idle | output | 1 | 1 when no frame is in progress |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input from the pad |

## Verification
The assertions assume two things about the inputs. First, mdio_i changes only while MDC is low and stays stable long enough for the two-stage synchronizer before each rising edge. Second, div_sel is not changed while a frame is running. The bench meets both conditions. Its PHY model drives a reply bit 1 ns after each falling MDC edge, which leaves at least four clocks before the next rise. The bench changes div_sel only while idle is 1 and pulses wr_en for a single cycle at falling clock edges.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int WORD_W   = 32;
  localparam int PREAMBLE = 32;
  localparam int FRAME_BITS = PREAMBLE + WORD_W;
  localparam int DATA_W   = 16;
  localparam int TA_POS   = PREAMBLE + 14;
  localparam int DATA_POS = PREAMBLE + (WORD_W - DATA_W);

  localparam logic [1:0] ST_OK = 2'b01;
  localparam logic [1:0] OP_WR = 2'b01;
  localparam logic [1:0] OP_RD = 2'b10;
  localparam logic [1:0] TA_OK = 2'b10;

  typedef struct packed {
    logic [1:0]        st;
    logic [1:0]        op;
    logic [4:0]        phy;
    logic [4:0]        rega;
    logic [1:0]        ta;
    logic [DATA_W-1:0] data;
  } mgmt_word_t;

  function automatic logic word_ok(mgmt_word_t w);
    return (w.st == ST_OK) && (w.ta == TA_OK) && ((w.op == OP_WR) || (w.op == OP_RD));
  endfunction
endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
  parameter int BASE_DIV = 8,
  parameter int SEL_W    = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             mdc,
  output logic             rise_tick,
  output logic             fall_tick
);
  localparam int MAX_HALF = (BASE_DIV / 2) << ((1 << SEL_W) - 1);
  localparam int CW = (MAX_HALF > 1) ? $clog2(MAX_HALF) : 1;

  logic [SEL_W-1:0] sel_q;
  logic [CW-1:0]    cnt;
  logic [CW-1:0]    last;
  logic             tick;

  assign last      = CW'(((BASE_DIV / 2) << sel_q) - 1);
  assign tick      = run && (cnt == last);
  assign rise_tick = tick && !mdc;
  assign fall_tick = tick && mdc;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      mdc   <= 1'b0;
      sel_q <= '0;
    end else if (!run) begin
      cnt   <= '0;
      mdc   <= 1'b0;
      sel_q <= sel;
    end else if (tick) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + CW'(1);
    end
  end

  // R5: a half period always lasts longer than one clock
  assert_mdc_min_half_R5: assert property (@(posedge clk) disable iff (rst)
    !$stable(mdc) |=> $stable(mdc));

  // R5: the ratio is frozen while a frame runs
  assert_sel_frozen_R5: assert property (@(posedge clk) disable iff (rst)
    (run && $past(run)) |-> $stable(sel_q));
endmodule

// File: rtl/mdio_in_sync.sv
module mdio_in_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] sr;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sr <= '0;
        else     sr <= din;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sr <= '0;
        else     sr <= {sr[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = sr[STAGES-1];
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              port_en,
  input  logic              rise_tick,
  input  logic              fall_tick,
  input  logic              din,
  output logic [WORD_W-1:0] word,
  output logic              busy,
  output logic              mdio_o,
  output logic              mdio_oe
);
  localparam int IDX_W = $clog2(FRAME_BITS);
  localparam logic [IDX_W-1:0] TA_IDX   = IDX_W'(TA_POS);
  localparam logic [IDX_W-1:0] DATA_IDX = IDX_W'(DATA_POS);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);
  localparam logic [IDX_W-1:0] PRE_IDX  = IDX_W'(PREAMBLE);

  mgmt_word_t       word_q;
  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] nxt;
  logic             is_read;
  logic             accept;
  logic             launch;
  mgmt_word_t       wr_word;

  function automatic logic bit_at(logic [IDX_W-1:0] i, logic [WORD_W-1:0] w);
    logic [$clog2(WORD_W)-1:0] pos;
    if (i < PRE_IDX) return 1'b1;
    pos = $clog2(WORD_W)'(WORD_W - 1 - (int'(i) - PREAMBLE));
    return w[pos];
  endfunction

  assign wr_word = mgmt_word_t'(wr_data);
  assign accept  = wr_en && !busy;
  assign launch  = accept && port_en && word_ok(wr_word);
  assign nxt     = idx + IDX_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q  <= '0;
      idx     <= '0;
      busy    <= 1'b0;
      is_read <= 1'b0;
      mdio_o  <= 1'b0;
      mdio_oe <= 1'b0;
    end else if (accept) begin
      word_q <= wr_word;
      if (launch) begin
        busy    <= 1'b1;
        idx     <= '0;
        is_read <= (wr_word.op == OP_RD);
        mdio_o  <= 1'b1;
        mdio_oe <= 1'b1;
      end
    end else if (busy) begin
      if (rise_tick && is_read && (idx >= DATA_IDX))
        word_q.data <= {word_q.data[DATA_W-2:0], din};
      if (fall_tick) begin
        if (idx == LAST_IDX) begin
          busy    <= 1'b0;
          mdio_o  <= 1'b0;
          mdio_oe <= 1'b0;
        end else begin
          idx <= nxt;
          if (is_read && (nxt >= TA_IDX)) begin
            mdio_o  <= 1'b0;
            mdio_oe <= 1'b0;
          end else begin
            mdio_o  <= bit_at(nxt, word_q);
            mdio_oe <= 1'b1;
          end
        end
      end
    end
  end

  assign word = word_q;

  // R10: a write during a frame leaves the word alone (outside capture edges)
  assert_busy_write_ignored_R10: assert property (@(posedge clk) disable iff (rst)
    (busy && wr_en && !rise_tick) |=> $stable(word_q));

  // R3: no frame starts without the port enable
  assert_launch_needs_enable_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(port_en));

  // R7: the driver is only switched on at the start of a frame
  assert_oe_rises_at_start_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(mdio_oe) |-> $rose(busy));

  // R8: the upper fields never change while a frame runs
  assert_upper_fields_kept_R8: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(word_q[WORD_W-1:DATA_W]));
endmodule

// File: rtl/mdio_frame_ctrl.sv
module mdio_frame_ctrl #(
  parameter int BASE_DIV    = 8,
  parameter int SEL_W       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [31:0]      wr_data,
  output logic [31:0]      rd_data,
  input  logic             port_en,
  input  logic [SEL_W-1:0] div_sel,
  output logic             idle,
  output logic             mdc,
  output logic             mdio_o,
  output logic             mdio_oe,
  input  logic             mdio_i
);
  logic busy;
  logic rise_tick;
  logic fall_tick;
  logic din_s;

  mdio_clk_div #(.BASE_DIV(BASE_DIV), .SEL_W(SEL_W)) u_div (
    .clk(clk), .rst(rst), .run(busy), .sel(div_sel),
    .mdc(mdc), .rise_tick(rise_tick), .fall_tick(fall_tick)
  );

  mdio_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(mdio_i), .dout(din_s)
  );

  mdio_frame_engine u_eng (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .port_en(port_en),
    .rise_tick(rise_tick), .fall_tick(fall_tick), .din(din_s),
    .word(rd_data), .busy(busy), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  assign idle = ~busy;

  // R9: no clock and no driver while idle
  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    idle |-> (!mdc && !mdio_oe));

  // R6: data changes only with the falling MDC edge
  assert_bit_change_on_fall_R6: assert property (@(posedge clk) disable iff (rst)
    (!idle && !$past(idle) && !$stable(mdio_o)) |-> $fell(mdc));
endmodule

// File: tb/mdio_frame_ctrl_test.sv
`timescale 1ns/1ps
module mdio_frame_ctrl_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en;
  logic [31:0] wr_data;
  logic [31:0] rd_data;
  logic        port_en;
  logic [1:0]  div_sel;
  logic        idle;
  logic        mdc;
  logic        mdio_o;
  logic        mdio_oe;
  logic        mdio_i;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  mdio_frame_ctrl uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .port_en(port_en), .div_sel(div_sel), .idle(idle), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  // bench capture of every rising MDC edge
  int      rises = 0;
  logic    cap_o  [0:79];
  logic    cap_oe [0:79];
  realtime t_rise = 0.0;
  realtime exp_period = 40.0;
  bit      timing_bad = 0;
  bit      rd_active = 0;
  logic [15:0] resp_q = '0;

  always @(posedge mdc) begin
    if (rises < 80) begin
      cap_o[rises]  = mdio_o;
      cap_oe[rises] = mdio_oe;
    end
    if (rises > 0 && (($realtime - t_rise) > exp_period + 0.1 ||
                      ($realtime - t_rise) < exp_period - 0.1))
      timing_bad = 1;
    t_rise = $realtime;
    rises++;
  end

  // PHY model: drives the reply bit shortly after each falling edge
  always @(negedge mdc) begin
    if ((($realtime - t_rise) > exp_period / 2 + 0.1) ||
        (($realtime - t_rise) < exp_period / 2 - 0.1))
      timing_bad = 1;
    #1;
    if (rd_active && rises >= 48 && rises <= 63)
      mdio_i = resp_q[63 - rises];
    else
      mdio_i = 1'b1;
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic write_word(input logic [31:0] w);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = w;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_idle();
    for (int n = 0; n < 20000; n++) begin
      @(negedge clk);
      if (idle) break;
    end
  endtask

  function automatic logic [31:0] mk(input logic [1:0] st, input logic [1:0] op,
                                     input logic [4:0] phy, input logic [4:0] ra,
                                     input logic [1:0] ta, input logic [15:0] d);
    return {st, op, phy, ra, ta, d};
  endfunction

  // {sel, is_read, phy, reg, data, reply}
  localparam logic [44:0] VECS [0:3] = '{
    {2'd0, 1'b0, 5'h01, 5'h04, 16'hA5C3, 16'h0000},
    {2'd1, 1'b1, 5'h1F, 5'h01, 16'hFFFF, 16'h796D},
    {2'd2, 1'b0, 5'h10, 5'h1F, 16'h0001, 16'h0000},
    {2'd3, 1'b1, 5'h00, 5'h02, 16'h0000, 16'h8001}
  };

  task automatic run_frame(input logic [31:0] w, input logic [1:0] sel,
                           input bit rd, input logic [15:0] reply);
    int bad_bits;
    int bad_oe;
    logic exp_bit;
    logic exp_oe;
    logic [31:0] exp_word;
    div_sel = sel;
    exp_period = real'(8 << sel) * 5.0;
    rd_active = rd;
    resp_q = reply;
    timing_bad = 0;
    rises = 0;
    write_word(w);
    @(negedge clk);
    check(idle == 1'b0, "R9 idle low during frame", {31'd0, idle}, 32'd0);
    wait_idle();
    check(rises == 64, "R4 bit count", rises, 64);
    bad_bits = 0;
    bad_oe = 0;
    for (int i = 0; i < 64; i++) begin
      exp_bit = (i < 32) ? 1'b1 : w[63 - i];
      exp_oe  = !(rd && i >= 46);
      if (cap_oe[i] !== exp_oe) bad_oe++;
      if (exp_oe && cap_o[i] !== exp_bit) bad_bits++;
    end
    check(bad_bits == 0, "R4 serial bit pattern", bad_bits, 0);
    check(bad_oe == 0, "R7 output enable pattern", bad_oe, 0);
    check(!timing_bad, "R5 MDC period and halves", {31'd0, timing_bad}, 0);
    exp_word = rd ? {w[31:16], reply} : w;
    check(rd_data == exp_word, rd ? "R8 read data captured" : "R2 word kept after write", rd_data, exp_word);
    check(!mdc && !mdio_oe && idle, "R9 quiet after frame", {29'd0, idle, mdc, mdio_oe}, 32'h4);
    rd_active = 0;
  endtask

  initial begin
    logic [31:0] w;
    rst = 1'b1; wr_en = 1'b0; wr_data = '0; port_en = 1'b0; div_sel = 2'd0; mdio_i = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(idle == 1'b1, "R1 idle after reset", {31'd0, idle}, 1);
    check(!mdc && !mdio_oe && !mdio_o, "R1 pins after reset", {29'd0, mdc, mdio_oe, mdio_o}, 0);
    check(rd_data == 32'd0, "R1 word after reset", rd_data, 0);

    // R3: port disabled, valid word stored but not sent
    w = mk(2'b01, 2'b01, 5'h03, 5'h00, 2'b10, 16'h1234);
    rises = 0;
    write_word(w);
    repeat (300) @(negedge clk);
    check(rises == 0 && idle, "R3 disabled port sends nothing", rises, 0);
    check(rd_data == w, "R2 word stored while disabled", rd_data, w);

    port_en = 1'b1;
    w = mk(2'b00, 2'b01, 5'h03, 5'h00, 2'b10, 16'h1234);
    rises = 0;
    write_word(w);
    repeat (300) @(negedge clk);
    check(rises == 0 && idle, "R3 bad start code", rises, 0);

    w = mk(2'b01, 2'b11, 5'h03, 5'h00, 2'b10, 16'h1234);
    rises = 0;
    write_word(w);
    repeat (300) @(negedge clk);
    check(rises == 0 && idle, "R3 bad op code", rises, 0);

    w = mk(2'b01, 2'b10, 5'h03, 5'h00, 2'b01, 16'h1234);
    rises = 0;
    write_word(w);
    repeat (300) @(negedge clk);
    check(rises == 0 && idle, "R3 bad turnaround code", rises, 0);

    // table walk: R4 R5 R7 R8 R9 over all ratios
    for (int v = 0; v < 4; v++) begin
      logic [44:0] e;
      e = VECS[v];
      w = mk(2'b01, e[42] ? 2'b10 : 2'b01, e[41:37], e[36:32], 2'b10, e[31:16]);
      run_frame(w, e[44:43], e[42], e[15:0]);
    end

    // R10: write while busy is ignored
    w = mk(2'b01, 2'b01, 5'h0A, 5'h05, 2'b10, 16'hC0DE);
    div_sel = 2'd0;
    exp_period = 40.0;
    rises = 0;
    timing_bad = 0;
    write_word(w);
    repeat (50) @(negedge clk);
    write_word(mk(2'b01, 2'b10, 5'h11, 5'h11, 2'b10, 16'h5555));
    @(negedge clk);
    check(rd_data == w, "R10 word unchanged after busy write", rd_data, w);
    wait_idle();
    check(rises == 64, "R10 frame not restarted", rises, 64);
    check(rd_data == w, "R10 word after frame", rd_data, w);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule